// File: doc/BRIEF.md
# Early-Terminating Iterative Divider

This block divides one 32-bit operand by another, one quotient bit per clock, for either signed or unsigned operands. It returns a quotient and a remainder. The caller pulses a start strobe with the operands and a signed flag. The block then raises busy until the result is ready, and the pipeline holds for that time. At the end it pulses done for one clock with the results on its outputs. The results stay there until the next division completes.

Before iterating, the block looks at the dividend in whole 8-bit groups from the top. It finds how many leading groups carry no information: groups that are all zero in an unsigned divide, or copies of the next lower bit in a signed one. Those groups contribute no quotient bits, so the dividend magnitude is preloaded already shifted past them and only the remaining bits are iterated. Small dividends therefore finish in 11, 19 or 27 clocks instead of 34. The signs are removed before iterating and put back afterwards. A zero divisor still finishes on schedule, but its results carry no meaning.

Top module: `earlyExitDivider`

## Requirements
- R1: After reset, busy and done are low, and quotient and remainder are zero.
- R2: A start pulse while busy is low is accepted: busy is high from the next clock edge until the result is delivered.
- R3: A start pulse while busy is high is ignored. The running division completes with its original operands and timing.
- R4: Done is high for exactly one clock per accepted division, and busy falls on the same edge that raises done. A new start may be accepted in the clock where done is high.
- R5: With the signed flag low, both operands are treated as unsigned. The quotient is floor(dividend / divisor) and the remainder is dividend minus quotient times divisor.
- R6: With the signed flag high, both operands are treated as two's complement. The quotient is truncated toward zero and the remainder carries the sign of the dividend. The dividend 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: When no leading 8-bit group of the dividend can be skipped, done rises 34 clock edges after the edge that accepted start.
- R8: Let k be the largest of 3, 2 or 1 for which the top 8k dividend bits all equal bit 31-8k in a signed divide, or are all zero in an unsigned divide. The latency is then 11 for k=3, 19 for k=2 and 27 for k=1.
- R9: A zero divisor never hangs the block. Done arrives at the latency that R7 and R8 give for that dividend, and the results are unspecified.
- R10: Quotient and remainder change only on the edge that raises done, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the operands present this cycle |
| isSigned | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-clock pulse: results valid |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
The assertions check the handshake on every clock: a start taken while idle raises busy, done is a single pulse that never overlaps busy, the results move only on done, and no busy period outlasts the worst-case latency. What they cannot show is whether the numbers are right, and whether each dividend lands in its latency class. The bench's reference model covers both, since it predicts busy, done and the results for each clock. Its scenarios cover unsigned and signed values, sign combinations, group boundaries such as 0x80 and -129, the overflow case, a zero divisor, starts issued mid-run, and starts issued back to back.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // capture raw operands
    logic prep;   // form magnitudes and sign flags
    logic align;  // shift dividend past skipped groups
    logic iter;   // one restoring step
    logic fix;    // apply signs, publish results
  } divCtrlT;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GRAIN = 8,
  localparam int NGRP = WIDTH / GRAIN,
  localparam int SKW = $clog2(NGRP)
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrlT          ctrl,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [SKW-1:0]   skipGroups,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic [WIDTH-1:0] aReg, bReg, quoReg, remReg, dvsReg;
  logic             sgnReg, negQ, negR;
  logic [NGRP-1:0]  grpMatch;

  // A group of k leading bytes is redundant when it equals the sign of what lies below.
  assign grpMatch[0] = 1'b1;
  for (genvar k = 1; k < NGRP; k++) begin : g_match
    logic extBit;
    assign extBit = sgnReg & aReg[WIDTH-1-k*GRAIN];
    assign grpMatch[k] = (aReg[WIDTH-1 -: k*GRAIN] == {(k*GRAIN){extBit}});
  end

  always_comb begin
    skipGroups = '0;
    for (int k = 1; k < NGRP; k++)
      if (grpMatch[k]) skipGroups = SKW'(k);
  end

  logic [WIDTH-1:0] magA, magB;
  assign magA = (sgnReg && aReg[WIDTH-1]) ? (~aReg + 1'b1) : aReg;
  assign magB = (sgnReg && bReg[WIDTH-1]) ? (~bReg + 1'b1) : bReg;

  logic [WIDTH:0] shifted, trial;
  assign shifted = {remReg, quoReg[WIDTH-1]};
  assign trial   = shifted - {1'b0, dvsReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0; sgnReg <= 1'b0;
      quoReg <= '0; remReg <= '0; dvsReg <= '0;
      negQ <= 1'b0; negR <= 1'b0;
      quotient <= '0; remainder <= '0;
    end else begin
      if (ctrl.load) begin
        aReg <= dividend; bReg <= divisor; sgnReg <= isSigned;
      end
      if (ctrl.prep) begin
        quoReg <= magA;
        dvsReg <= magB;
        remReg <= '0;
        negQ   <= sgnReg & (aReg[WIDTH-1] ^ bReg[WIDTH-1]);
        negR   <= sgnReg & aReg[WIDTH-1];
      end
      if (ctrl.align)
        quoReg <= quoReg << (int'(skipGroups) * GRAIN);
      if (ctrl.iter) begin
        if (!trial[WIDTH]) begin
          remReg <= trial[WIDTH-1:0];
          quoReg <= {quoReg[WIDTH-2:0], 1'b1};
        end else begin
          remReg <= shifted[WIDTH-1:0];
          quoReg <= {quoReg[WIDTH-2:0], 1'b0};
        end
      end
      if (ctrl.fix) begin
        quotient  <= negQ ? (~quoReg + 1'b1) : quoReg;
        remainder <= negR ? (~remReg + 1'b1) : remReg;
      end
    end
  end
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GRAIN = 8,
  localparam int NGRP = WIDTH / GRAIN,
  localparam int SKW = $clog2(NGRP),
  localparam int CNTW = $clog2(WIDTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [SKW-1:0] skipGroups,
  output divCtrlT        ctrl,
  output logic           busy,
  output logic           done
);
  typedef enum logic [2:0] {S_IDLE, S_PREP, S_ALIGN, S_ITER, S_FIX} stateT;
  stateT            state;
  logic [CNTW-1:0]  bitsLeft;

  always_comb begin
    ctrl       = '0;
    ctrl.load  = (state == S_IDLE) && start;
    ctrl.prep  = (state == S_PREP);
    ctrl.align = (state == S_ALIGN);
    ctrl.iter  = (state == S_ITER);
    ctrl.fix   = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE:  if (start) state <= S_PREP;
        S_PREP: begin
          bitsLeft <= CNTW'(WIDTH - int'(skipGroups) * GRAIN);
          state    <= (skipGroups != '0) ? S_ALIGN : S_ITER;
        end
        S_ALIGN: state <= S_ITER;
        S_ITER: begin
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == CNTW'(1)) state <= S_FIX;
        end
        S_FIX: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/earlyExitDivider.sv
module earlyExitDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GRAIN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int SKW = $clog2(WIDTH / GRAIN);

  divCtrlT        ctrl;
  logic [SKW-1:0] skipGroups;

  divControl #(.WIDTH(WIDTH), .GRAIN(GRAIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .skipGroups(skipGroups),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH), .GRAIN(GRAIN)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .skipGroups(skipGroups),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/earlyExitDividerChecker.sv
module earlyExitDividerChecker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  localparam int MAXLAT = WIDTH + 2;
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else       busyRun <= busy ? busyRun + 1 : 0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(quotient) || !$stable(remainder)) |-> done);

  p_bounded_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < MAXLAT));
endmodule

bind earlyExitDivider earlyExitDividerChecker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/earlyExitDivider_test.sv
module earlyExitDivider_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isSigned = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  always #2 clk = ~clk;  // 250 MHz

  earlyExitDivider uut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  // Reference model state
  bit          mBusy = 0, mDone = 0, mValid = 1;
  int          mLeft = 0;
  logic [31:0] mQ = '0, mR = '0, pQ, pR;
  bit          pZero;

  function automatic int refLatency(logic [31:0] a, bit s);
    for (int k = 3; k >= 1; k--) begin
      bit ok = 1;
      bit ref_bit = s ? a[31 - 8*k] : 1'b0;
      for (int i = 31; i > 31 - 8*k; i--)
        if (a[i] !== ref_bit) ok = 0;
      if (ok) return 34 - 8*k + 1;
    end
    return 34;
  endfunction

  function automatic logic [63:0] refDiv(logic [31:0] a, logic [31:0] b, bit s);
    longint x, y, q, r;
    if (s) begin x = longint'($signed(a)); y = longint'($signed(b)); end
    else   begin x = longint'({32'b0, a}); y = longint'({32'b0, b}); end
    q = x / y;
    r = x % y;
    return {q[31:0], r[31:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mValid = 1; mQ = '0; mR = '0; mLeft = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1;
          if (pZero) mValid = 0;
          else begin mValid = 1; mQ = pQ; mR = pR; end
        end
      end else if (start) begin
        logic [63:0] res;
        mBusy = 1;
        mLeft = refLatency(dividend, isSigned);
        pZero = (divisor == 0);
        if (!pZero) begin res = refDiv(dividend, divisor, isSigned); pQ = res[63:32]; pR = res[31:0]; end
      end
    end
  end

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({busy, done} === {mBusy, mDone}, "busy/done", {62'b0, busy, done}, {62'b0, mBusy, mDone});
      if (mValid)
        check({quotient, remainder} === {mQ, mR}, "quotient/remainder",
              {quotient, remainder}, {mQ, mR});
    end
  end

  task automatic runDiv(logic [31:0] a, logic [31:0] b, bit s, string tag);
    curReq = tag;
    start = 1; dividend = a; divisor = b; isSigned = s;
    @(negedge clk);
    start = 0; dividend = $urandom; divisor = $urandom; isSigned = $urandom;
    while (mBusy) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    check({busy, done, quotient, remainder} === 66'b0, "reset state",
          {busy, done, quotient[31:0], remainder[29:0]}, 64'b0);

    // R5 unsigned, each latency class (R7, R8)
    runDiv(32'd100, 32'd7, 0, "R8");
    runDiv(32'h0000_1234, 32'h13, 0, "R8");
    runDiv(32'h0012_3456, 32'd3, 0, "R8");
    runDiv(32'hFFFF_FFFF, 32'h10, 0, "R7");
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 0, "R5");
    runDiv(32'h0000_0080, 32'd3, 0, "R8");
    runDiv(32'd5, 32'd9, 0, "R5");
    // R6 signed, sign combinations and boundaries
    runDiv(-32'sd100, 32'sd7, 1, "R6");
    runDiv(32'sd100, -32'sd7, 1, "R6");
    runDiv(-32'sd100, -32'sd7, 1, "R6");
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1, "R6");
    runDiv(32'h8000_0000, 32'd3, 1, "R7");
    runDiv(-32'sd129, 32'sd4, 1, "R8");
    runDiv(-32'sd128, 32'sd5, 1, "R8");
    runDiv(32'h0000_0080, 32'd3, 1, "R8");
    runDiv(32'hFF80_0000, 32'd1000, 1, "R8");
    // R9 zero divisor then a normal divide
    runDiv(32'h1234_5678, 32'd0, 0, "R9");
    runDiv(32'd42, 32'd0, 1, "R9");
    runDiv(32'd1000, 32'd10, 0, "R9");
    // R3 start while busy
    curReq = "R3";
    start = 1; dividend = 32'hFFFF_0000; divisor = 32'd7; isSigned = 0;
    @(negedge clk);
    dividend = 32'd9; divisor = 32'd2;
    repeat (5) @(negedge clk);
    start = 0;
    while (mBusy) @(negedge clk);
    // R4 back-to-back: next start lands in the done cycle
    runDiv(32'd77, 32'd5, 0, "R4");
    runDiv(32'h7FFF_FFFF, 32'd2, 1, "R4");
    // R10 outputs hold while idle and random traffic
    curReq = "R10";
    repeat (10) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      if (i % 4 == 1) a = a >> 24;
      if (i % 4 == 2) a = {{16{a[15]}}, a[15:0]};
      if (i % 5 == 0) b = b >> 20;
      runDiv(a, (b == 0) ? 32'd1 : b, i[0], (i[0]) ? "R6" : "R5");
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule